// File: doc/BRIEF.md
# Snapshot Buffer Readout Sequencer

This block decides which word of a 32-entry snapshot buffer is read and whether each read request is honoured. Software programs a command register with a start address, a count-minus-one and a handful of control bits. Readout can be armed by a load event or by a readout-enable bit. Either way the block reloads its read pointer and its remaining-word counter, then waits a fixed settling time before it accepts reads.

Two read functions are served. The sequential read returns the word at the pointer, advances the pointer modulo 32 and counts down the remaining words. The addressed read returns the word at the pointer and leaves it unchanged. Every command gets a registered response one cycle later. The response carries an X bit for a recognised function code, a Q bit for an allowed operation, and the data word. The buffer memory is external: the block drives its address and takes the word back in the same cycle.

The control state machine has four states:

- `ST_IDLE`: not armed.
- `ST_SETTLE`: armed, settling timer running.
- `ST_ACTIVE`: settled, words remain.
- `ST_DRAINED`: settled, count exhausted.

Its transitions are:

- arm: any state to `ST_SETTLE`.
- settle done: `ST_SETTLE` to `ST_ACTIVE`.
- last word: `ST_ACTIVE` to `ST_DRAINED`.

Top module: `readout_seq`

## Requirements
- R1: After reset the start address is 0, the count-minus-one is 31, the test and bus-disable levels are 0, the block is idle, and every read answers Q=0.
- R2: Function code 16 writes the command register and always answers Q=1, X=1 with zero data. The data layout is: start address in bits 4:0, count-minus-one in bits 9:5, test at bit 10, load at bit 11, clear at bit 12, readout-enable at bit 13, bus-disable at bit 14.
- R3: X=1 is returned for function codes 0, 2 and 16 only. Any other code answers X=0, Q=0 and zero data.
- R4: Arming reloads the pointer with the start address and the remaining count with count-minus-one plus 1. Arming is caused by a load (write bit 11 or the `load_pulse` input) or by write bit 13. Values written in the same command take effect. Arming during an active window restarts it.
- R5: For SETTLE_CYCLES (default 80) clock edges after the arming edge, reads answer Q=0 and change neither pointer nor count.
- R6: A sequential read (code 2) with Q=1 returns the word at the pointer, then advances the pointer modulo 32 (31 wraps to 0) and decrements the remaining count.
- R7: A sequential read answers Q=1 only if readout was armed by a load, settling is over and words remain, whatever `latch_dis` is.
- R8: With `latch_dis`=1, an addressed read (code 0) answers Q=1 whenever readout is armed and settled, even without a load or after the count is exhausted.
- R9: With `latch_dis`=0, an addressed read answers Q=1 only after a load, once settled, while words remain. An addressed read never moves the pointer.
- R10: A read answering Q=0 returns zero data and changes neither pointer nor count.
- R11: With `latch_dis`=1, load requests (write bit 11 and `load_pulse`) do not arm readout.
- R12: `test_en` and `bus_dis` follow the last written bits 10 and 14. Write bit 12 raises `clr_pulse` for exactly one cycle after the write.
- R13: The response (`rsp_valid`, `rsp_x`, `rsp_q`, `rsp_data`) appears on the clock edge after the command is sampled and lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_func | input | 5 | Function code (0 addressed read, 2 sequential read, 16 register write) |
| cmd_wdata | input | 15 | Command register write data |
| load_pulse | input | 1 | External load event |
| latch_dis | input | 1 | Latching-disable option |
| buf_addr | output | 5 | Snapshot buffer read address (the pointer) |
| buf_rdata | input | 24 | Snapshot buffer word at buf_addr |
| rsp_valid | output | 1 | Response strobe |
| rsp_x | output | 1 | Function code recognised |
| rsp_q | output | 1 | Operation allowed |
| rsp_data | output | 24 | Read data, zero when Q=0 |
| test_en | output | 1 | Test level from the command register |
| bus_dis | output | 1 | Auxiliary bus disable level |
| clr_pulse | output | 1 | One-cycle clear request |

## Verification
The bound checker watches several properties on every cycle:

- response timing relative to the command strobe;
- the set of codes that answer X=1, and the unconditional Q=1 of a register write;
- the zero data behind every refused read;
- refusal of every read while idle or settling, and of sequential reads without a load;
- the pointer moving by exactly one after a granted sequential read.

Some behaviours only the bench scenarios can show. These are the reset values of the address window, the exact cycle at which settling ends, the wrap from 31 to 0, and the point at which the count runs out. They also include the two latching-disable regimes of the addressed read and the restart of a window by re-arming.

// File: rtl/rs_pkg.sv
package rs_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_SETTLE  = 2'd1,
        ST_ACTIVE  = 2'd2,
        ST_DRAINED = 2'd3
    } rs_state_e;

    localparam logic [4:0] FN_ADDR_RD = 5'd0;
    localparam logic [4:0] FN_SEQ_RD  = 5'd2;
    localparam logic [4:0] FN_CFG_WR  = 5'd16;

endpackage

// File: rtl/rs_cmd_reg.sv
module rs_cmd_reg #(
    parameter int ADDR_W = 5
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [2*ADDR_W+4:0]   wr_data,
    output logic [ADDR_W-1:0]     eff_fa,
    output logic [ADDR_W-1:0]     eff_rn,
    output logic                  ld_req,
    output logic                  rd_req,
    output logic                  test_en,
    output logic                  bus_dis,
    output logic                  clr_pulse
);
    localparam int B_TEST = 2*ADDR_W;
    localparam int B_LOAD = 2*ADDR_W + 1;
    localparam int B_CLR  = 2*ADDR_W + 2;
    localparam int B_RDEN = 2*ADDR_W + 3;
    localparam int B_BDIS = 2*ADDR_W + 4;

    logic [ADDR_W-1:0] fa_q;
    logic [ADDR_W-1:0] rn_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fa_q      <= '0;
            rn_q      <= '1;
            test_en   <= 1'b0;
            bus_dis   <= 1'b0;
            clr_pulse <= 1'b0;
        end else begin
            clr_pulse <= wr_en & wr_data[B_CLR];
            if (wr_en) begin
                fa_q    <= wr_data[ADDR_W-1:0];
                rn_q    <= wr_data[2*ADDR_W-1:ADDR_W];
                test_en <= wr_data[B_TEST];
                bus_dis <= wr_data[B_BDIS];
            end
        end
    end

    // Values in effect this cycle, including a write sampled now
    assign eff_fa = wr_en ? wr_data[ADDR_W-1:0]        : fa_q;
    assign eff_rn = wr_en ? wr_data[2*ADDR_W-1:ADDR_W] : rn_q;
    assign ld_req = wr_en & wr_data[B_LOAD];
    assign rd_req = wr_en & wr_data[B_RDEN];

endmodule

// File: rtl/rs_settle_timer.sv
module rs_settle_timer #(
    parameter int SETTLE_CYCLES = 80
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic run,
    output logic done
);
    localparam int CNT_W = $clog2(SETTLE_CYCLES + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(SETTLE_CYCLES - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (start)
            cnt_q <= '0;
        else if (run && !done)
            cnt_q <= cnt_q + 1'b1;
    end

    assign done = run && (cnt_q == LAST);

endmodule

// File: rtl/rs_window.sv
module rs_window #(
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_ptr,
    input  logic [ADDR_W-1:0] load_rn,
    input  logic              step,
    output logic [ADDR_W-1:0] ptr,
    output logic              last
);
    localparam int CNT_W = ADDR_W + 1;

    logic [CNT_W-1:0] remain_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr      <= '0;
            remain_q <= '0;
        end else if (load) begin
            ptr      <= load_ptr;
            remain_q <= {1'b0, load_rn} + 1'b1;
        end else if (step) begin
            ptr      <= ptr + 1'b1;   // natural wrap modulo 2**ADDR_W
            remain_q <= remain_q - 1'b1;
        end
    end

    assign last = (remain_q == CNT_W'(1));

endmodule

// File: rtl/readout_seq.sv
module readout_seq
    import rs_pkg::*;
#(
    parameter int ADDR_W        = 5,
    parameter int DATA_W        = 24,
    parameter int SETTLE_CYCLES = 80
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cmd_valid,
    input  logic [4:0]          cmd_func,
    input  logic [2*ADDR_W+4:0] cmd_wdata,
    input  logic                load_pulse,
    input  logic                latch_dis,
    output logic [ADDR_W-1:0]   buf_addr,
    input  logic [DATA_W-1:0]   buf_rdata,
    output logic                rsp_valid,
    output logic                rsp_x,
    output logic                rsp_q,
    output logic [DATA_W-1:0]   rsp_data,
    output logic                test_en,
    output logic                bus_dis,
    output logic                clr_pulse
);
    rs_state_e st_q, st_d;

    logic              is_wr, is_seq, is_addr;
    logic              ld_req, rd_req, load_evt, arm;
    logic [ADDR_W-1:0] eff_fa, eff_rn;
    logic              settle_done, win_last;
    logic              loaded_q;
    logic              seq_ok, addr_ok, step;

    assign is_wr   = cmd_valid && (cmd_func == FN_CFG_WR);
    assign is_seq  = cmd_valid && (cmd_func == FN_SEQ_RD);
    assign is_addr = cmd_valid && (cmd_func == FN_ADDR_RD);

    rs_cmd_reg #(.ADDR_W(ADDR_W)) u_cmd (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (is_wr),
        .wr_data   (cmd_wdata),
        .eff_fa    (eff_fa),
        .eff_rn    (eff_rn),
        .ld_req    (ld_req),
        .rd_req    (rd_req),
        .test_en   (test_en),
        .bus_dis   (bus_dis),
        .clr_pulse (clr_pulse)
    );

    assign load_evt = (ld_req || load_pulse) && !latch_dis;
    assign arm      = load_evt || rd_req;

    rs_settle_timer #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (arm),
        .run   (st_q == ST_SETTLE),
        .done  (settle_done)
    );

    // Read grants
    assign seq_ok  = is_seq && loaded_q && (st_q == ST_ACTIVE);
    assign addr_ok = is_addr && (latch_dis
                     ? ((st_q == ST_ACTIVE) || (st_q == ST_DRAINED))
                     : (loaded_q && (st_q == ST_ACTIVE)));
    assign step    = seq_ok && !arm;

    rs_window #(.ADDR_W(ADDR_W)) u_win (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (arm),
        .load_ptr (eff_fa),
        .load_rn  (eff_rn),
        .step     (step),
        .ptr      (buf_addr),
        .last     (win_last)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= ST_IDLE;
            loaded_q <= 1'b0;
        end else begin
            st_q <= st_d;
            if (arm)
                loaded_q <= load_evt;
        end
    end

    // Transitions
    always_comb begin
        st_d = st_q;
        if (arm) begin
            st_d = ST_SETTLE;
        end else begin
            unique case (st_q)
                ST_IDLE:    st_d = ST_IDLE;
                ST_SETTLE:  if (settle_done)       st_d = ST_ACTIVE;
                ST_ACTIVE:  if (step && win_last)  st_d = ST_DRAINED;
                ST_DRAINED: st_d = ST_DRAINED;
                default:    st_d = ST_IDLE;
            endcase
        end
    end

    // Response outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_x     <= 1'b0;
            rsp_q     <= 1'b0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= cmd_valid;
            rsp_x     <= is_wr || is_seq || is_addr;
            rsp_q     <= is_wr || seq_ok || addr_ok;
            rsp_data  <= (seq_ok || addr_ok) ? buf_rdata : '0;
        end
    end

endmodule

// File: rtl/rs_checker.sv
module rs_checker
    import rs_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_valid,
    input logic [4:0]        cmd_func,
    input logic              load_pulse,
    input logic [ADDR_W-1:0] buf_addr,
    input logic              rsp_valid,
    input logic              rsp_x,
    input logic              rsp_q,
    input logic [DATA_W-1:0] rsp_data,
    input logic [1:0]        st,
    input logic              loaded
);
    assert_rsp_follows_R13: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> rsp_valid);

    assert_rsp_one_cycle_R13: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |=> !rsp_valid);

    assert_x_codes_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> (rsp_x == ($past(cmd_func) == FN_ADDR_RD ||
                                 $past(cmd_func) == FN_SEQ_RD ||
                                 $past(cmd_func) == FN_CFG_WR)));

    assert_write_q_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_func == FN_CFG_WR) |=> rsp_q);

    assert_zero_data_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_q) |-> (rsp_data == '0));

    assert_idle_refuse_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_func != FN_CFG_WR && st == 2'(ST_IDLE)) |=> !rsp_q);

    assert_settle_refuse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_func != FN_CFG_WR && st == 2'(ST_SETTLE)) |=> !rsp_q);

    assert_seq_needs_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_func == FN_SEQ_RD && !loaded) |=> !rsp_q);

    assert_seq_advance_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_func == FN_SEQ_RD && !load_pulse) |=>
            (!rsp_q || buf_addr == $past(buf_addr) + 1'b1));

endmodule

bind readout_seq rs_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rs_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .cmd_func   (cmd_func),
    .load_pulse (load_pulse),
    .buf_addr   (buf_addr),
    .rsp_valid  (rsp_valid),
    .rsp_x      (rsp_x),
    .rsp_q      (rsp_q),
    .rsp_data   (rsp_data),
    .st         (st_q),
    .loaded     (loaded_q)
);

// File: tb/sim_readout_seq.sv
module sim_readout_seq;
    localparam int AW = 5;
    localparam int DW = 24;
    localparam int CW = 2*AW + 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic [4:0]    cmd_func = '0;
    logic [CW-1:0] cmd_wdata = '0;
    logic          load_pulse = 1'b0;
    logic          latch_dis = 1'b0;
    logic [AW-1:0] buf_addr;
    logic [DW-1:0] buf_rdata;
    logic          rsp_valid, rsp_x, rsp_q;
    logic [DW-1:0] rsp_data;
    logic          test_en, bus_dis, clr_pulse;

    int n_chk = 0;
    int n_err = 0;
    bit done_flag = 0;

    always #2 clk = ~clk;

    function automatic logic [DW-1:0] mem(input logic [AW-1:0] a);
        return DW'(a) * 24'h010101 + 24'h00000B;
    endfunction

    assign buf_rdata = mem(buf_addr);

    readout_seq u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_func(cmd_func),
        .cmd_wdata(cmd_wdata), .load_pulse(load_pulse), .latch_dis(latch_dis),
        .buf_addr(buf_addr), .buf_rdata(buf_rdata), .rsp_valid(rsp_valid),
        .rsp_x(rsp_x), .rsp_q(rsp_q), .rsp_data(rsp_data), .test_en(test_en),
        .bus_dis(bus_dis), .clr_pulse(clr_pulse)
    );

    function automatic logic [CW-1:0] cfg(input int fa, input int rn, input bit t,
                                          input bit ld, input bit cl, input bit rd,
                                          input bit bd);
        return {bd, rd, cl, ld, t, AW'(rn), AW'(fa)};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic issue(input logic [4:0] f, input logic [CW-1:0] d);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_func = f; cmd_wdata = d;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_func = '0; cmd_wdata = '0;
    endtask

    // Issue a read and check response Q, X and data for the given pointer
    task automatic rd(input string req, input logic [4:0] f, input bit q, input int a);
        issue(f, '0);
        chk({req, " q"}, 32'(rsp_q), 32'(q));
        chk({req, " x"}, 32'(rsp_x), 32'd1);
        chk({req, " data"}, 32'(rsp_data), q ? 32'(mem(AW'(a))) : 32'd0);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic ext_load();
        @(negedge clk); load_pulse = 1'b1;
        @(negedge clk); load_pulse = 1'b0;
    endtask

    task automatic settle();
        repeat (90) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    endtask

    // func, wdata, q, x, addr
    localparam int VW = 5 + CW + 1 + 1 + AW;
    localparam logic [VW-1:0] VEC [0:9] = '{
        {5'd2,  15'h0000, 1'b1, 1'b1, 5'd30},
        {5'd0,  15'h0000, 1'b1, 1'b1, 5'd31},
        {5'd2,  15'h0000, 1'b1, 1'b1, 5'd31},
        {5'd2,  15'h0000, 1'b1, 1'b1, 5'd0},
        {5'd0,  15'h0000, 1'b1, 1'b1, 5'd1},
        {5'd2,  15'h0000, 1'b1, 1'b1, 5'd1},
        {5'd2,  15'h0000, 1'b0, 1'b1, 5'd0},
        {5'd0,  15'h0000, 1'b0, 1'b1, 5'd0},
        {5'd8,  15'h0000, 1'b0, 1'b0, 5'd0},
        {5'd16, 15'h4000, 1'b1, 1'b1, 5'd0}
    };

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        // Reset state (R1)
        do_reset();
        @(negedge clk);
        chk("R1 rsp_valid", 32'(rsp_valid), 0);
        chk("R1 bus_dis", 32'(bus_dis), 0);
        chk("R1 test_en", 32'(test_en), 0);
        chk("R1 clr_pulse", 32'(clr_pulse), 0);
        rd("R1 R7 seq idle", 5'd2, 0, 0);
        rd("R1 addr idle", 5'd0, 0, 0);

        // Vector table: window FA=30 RN=3 wrapping past 31 (R2 R4 R6 R9 R3)
        issue(5'd16, cfg(30, 3, 0, 1, 0, 0, 0));
        chk("R2 write q", 32'(rsp_q), 1);
        chk("R2 write x", 32'(rsp_x), 1);
        settle();
        for (int i = 0; i < 10; i++) begin
            logic [VW-1:0] v;
            logic [4:0] f;
            logic eq, ex;
            logic [AW-1:0] ea;
            v  = VEC[i];
            f  = v[VW-1 -: 5];
            eq = v[AW+1];
            ex = v[AW];
            ea = v[AW-1:0];
            issue(f, v[VW-6 -: CW]);
            chk($sformatf("R6 R9 R3 vec%0d q", i), 32'(rsp_q), 32'(eq));
            chk($sformatf("R3 vec%0d x", i), 32'(rsp_x), 32'(ex));
            chk($sformatf("R10 vec%0d data", i), 32'(rsp_data),
                (eq && f != 5'd16) ? 32'(mem(ea)) : 32'd0);
        end
        chk("R12 bus_dis set", 32'(bus_dis), 1);

        // Default window after reset: 32 words from 0, then exhausted (R1 R6)
        do_reset();
        ext_load();
        settle();
        for (int i = 0; i < 32; i++) rd("R1 R6 default window", 5'd2, 1, i);
        rd("R6 count exhausted", 5'd2, 0, 0);

        // Settling boundary, refused read changes nothing (R5 R10)
        issue(5'd16, cfg(4, 1, 0, 1, 0, 0, 0));
        repeat (78) @(negedge clk);
        rd("R5 last settle edge", 5'd0, 0, 0);
        rd("R5 R10 first after settle", 5'd2, 1, 4);
        rd("R6 second word", 5'd2, 1, 5);
        rd("R10 count intact then drained", 5'd2, 0, 0);

        // Readout enable without load, latching disabled (R5 R8 R7)
        latch_dis = 1'b1;
        issue(5'd16, cfg(9, 0, 0, 0, 0, 1, 0));
        repeat (79) @(negedge clk);
        rd("R5 R8 edge after settle", 5'd0, 1, 9);
        rd("R7 seq without load", 5'd2, 0, 0);
        rd("R8 R9 addr no advance", 5'd0, 1, 9);

        // Loads ignored while latching disabled (R11)
        do_reset();
        latch_dis = 1'b1;
        issue(5'd16, cfg(3, 5, 0, 1, 0, 0, 0));
        chk("R2 R11 write q", 32'(rsp_q), 1);
        settle();
        rd("R11 load bit ignored", 5'd0, 0, 0);
        ext_load();
        settle();
        rd("R11 load pulse ignored", 5'd0, 0, 0);

        // Re-arm restarts the window (R4)
        latch_dis = 1'b0;
        issue(5'd16, cfg(20, 2, 0, 1, 0, 0, 0));
        settle();
        rd("R4 window start", 5'd2, 1, 20);
        issue(5'd16, cfg(7, 0, 0, 1, 0, 0, 0));
        settle();
        rd("R4 restart", 5'd2, 1, 7);
        rd("R4 restart count", 5'd2, 0, 0);

        // Control levels and clear pulse, response timing (R12 R13)
        issue(5'd16, cfg(0, 0, 1, 0, 1, 0, 0));
        chk("R13 rsp_valid", 32'(rsp_valid), 1);
        chk("R12 clr_pulse high", 32'(clr_pulse), 1);
        chk("R12 test_en", 32'(test_en), 1);
        chk("R12 bus_dis cleared", 32'(bus_dis), 0);
        @(negedge clk);
        chk("R13 rsp one cycle", 32'(rsp_valid), 0);
        chk("R12 clr_pulse low", 32'(clr_pulse), 0);

        finish_run();
    end

endmodule